// File: doc/BRIEF.md
# Heap Capability Revocation Sweeper

The block is a background engine that scans a software-chosen window of tagged memory one 8-byte slot at a time. Each slot holds a 64-bit word plus a validity tag. When the tag is set and the slot's low 32-bit word points into the protected heap, the engine fetches one byte of a revocation bitmap. If the bit covering that heap granule is set, the engine writes the slot back unchanged except for a cleared tag. Slots that fail any of these tests are left alone.

Software programs the window limits through a small 32-bit register set and starts a sweep through a trigger register. It can then poll a counter word that carries the completion count and a running flag, or wait for a level interrupt. The pace of the scan is set by an external timer pulse. Only every `PERIOD`-th pulse seen while the engine waits advances the scan, so the sweep takes only a small share of memory bandwidth. Each memory port uses a valid/ready request and a single-beat response. Only one access is outstanding at any time, across both ports.

Top module: `revoke_sweeper`

## Requirements
- R1: Registers sit at offsets 0x0 (window start), 0x4 (window end), 0x8 (trigger), 0xC (sweep counter), 0x10 (status) and 0x14 (interrupt enable), decoded from the 16-bit offset input. Start and end read back exactly as written. Reads of any other offset return zero, and writes to them change no register.
- R2: A read of the trigger register returns 0x55 in bits 31:24 and the last written trigger value's bits 23:0 in bits 23:0. Every trigger write stores its value, even while a sweep runs.
- R3: A trigger write starts a sweep only while no sweep runs. The start zeroes the slot index, the pulse count and the completion count. A trigger write during a sweep neither restarts nor stops it.
- R4: The sweep counter register reads as (count << 1) | running. Writes to it are ignored.
- R5: While running, the engine counts timer pulses that arrive while it waits. Every `PERIOD`-th counted pulse handles one slot and restarts the count. A sweep that touches K slot positions ends on pulse (K+1)·`PERIOD`.
- R6: Slot i sits at (start + 8·i) with bits 2:0 cleared. A slot address below start causes no memory access. When a slot address is at or beyond end, the sweep stops, the count increments and the status flag sets, with no memory access.
- R7: A slot read with a clear tag causes no bitmap read and no write.
- R8: The bitmap is consulted only for a pointer p with HEAP_BASE ≤ p < HEAP_BASE + HEAP_SIZE. The engine reads byte BM_BASE + ((p − HEAP_BASE) >> 6) and tests the bit numbered by (p − HEAP_BASE) bits 5:3.
- R9: If that bit is 1, the slot is written with the same 64-bit word and a cleared tag. Otherwise nothing is written.
- R10: The interrupt enable keeps only bit 0. A status read returns the status flag when enable is 1 and zero otherwise. Any write to status clears the flag. The interrupt output is the status flag ANDed with enable.
- R11: A memory request keeps its address, write flag and write data stable until accepted. The engine never requests on both ports at once and never issues a new access before the previous response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timer pulse that paces the sweep |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 16 | Register offset within the block window |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| hm_req_o | output | 1 | Tagged-memory request valid |
| hm_we_o | output | 1 | Tagged-memory request is a write |
| hm_addr_o | output | 32 | Tagged-memory slot address |
| hm_wdata_o | output | 64 | Tagged-memory write word |
| hm_wtag_o | output | 1 | Tagged-memory write tag |
| hm_gnt_i | input | 1 | Tagged-memory request accepted |
| hm_rvalid_i | input | 1 | Tagged-memory response valid |
| hm_rdata_i | input | 64 | Tagged-memory read word |
| hm_rtag_i | input | 1 | Tagged-memory read tag |
| bm_req_o | output | 1 | Bitmap read request valid |
| bm_addr_o | output | 32 | Bitmap byte address |
| bm_gnt_i | input | 1 | Bitmap request accepted |
| bm_rvalid_i | input | 1 | Bitmap response valid |
| bm_rdata_i | input | 8 | Bitmap byte |
| irq_o | output | 1 | Level interrupt for sweep completion |

## Verification
Register reads are combinational. The bench sets the offset at a falling edge and samples 1 ns later. A write takes effect at the next rising edge, so it is visible at the following falling-edge read. A slot decision is taken at the rising edge that sees the qualifying pulse. Each memory access then costs an accept cycle plus one response cycle. For that reason the bench separates pulses by 16 idle cycles, which is enough for the longest read–bitmap–write chain with grant stalls, and reads the counter register only after that gap. The count of pulses until the running bit clears, the number of accesses per port, and the final memory image are then compared with values the bench derives from the address arithmetic.

// File: rtl/revsw_pkg.sv
package revsw_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 64;
  localparam int OFS_W  = 16;

  typedef logic [ADDR_W-1:0] addr_t;

  localparam logic [OFS_W-1:0] OFS_START = 16'h0000;
  localparam logic [OFS_W-1:0] OFS_END   = 16'h0004;
  localparam logic [OFS_W-1:0] OFS_TRIG  = 16'h0008;
  localparam logic [OFS_W-1:0] OFS_CNT   = 16'h000C;
  localparam logic [OFS_W-1:0] OFS_STAT  = 16'h0010;
  localparam logic [OFS_W-1:0] OFS_IEN   = 16'h0014;
  localparam logic [7:0]       TRIG_SIG  = 8'h55;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_HRD, ST_HRW, ST_BRQ, ST_BRW, ST_HWR, ST_HWW
  } eng_st_e;

  // address of slot idx, forced to 8-byte alignment
  function automatic addr_t slot_addr(addr_t base, logic [ADDR_W-4:0] idx);
    addr_t a;
    a = base + {idx, 3'b000};
    return {a[ADDR_W-1:3], 3'b000};
  endfunction

  function automatic logic in_heap(addr_t p, addr_t hbase, addr_t hsize);
    return (p >= hbase) && ((p - hbase) < hsize);
  endfunction

  function automatic addr_t bm_byte(addr_t p, addr_t hbase, addr_t bbase);
    addr_t off;
    off = p - hbase;
    return bbase + (off >> 6);
  endfunction

  function automatic logic [2:0] bm_bit(addr_t p, addr_t hbase);
    addr_t off;
    off = p - hbase;
    return off[5:3];
  endfunction
endpackage

// File: rtl/revsw_regs.sv
module revsw_regs
  import revsw_pkg::*;
#(
  parameter int EPOCH_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [OFS_W-1:0] addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic             busy_i,
  input  logic             done_i,
  output logic             start_o,
  output addr_t            win_start_o,
  output addr_t            win_end_o,
  output logic             ien_o,
  output logic             irq_o
);
  localparam int PAD_W = 31 - EPOCH_W;

  addr_t              start_q, end_q;
  logic [23:0]        trig_q;
  logic [EPOCH_W-1:0] epoch_q;
  logic               stat_q, ien_q;

  logic wr_start, wr_end, wr_trig, wr_stat, wr_ien;
  assign wr_start = we_i && (addr_i == OFS_START);
  assign wr_end   = we_i && (addr_i == OFS_END);
  assign wr_trig  = we_i && (addr_i == OFS_TRIG);
  assign wr_stat  = we_i && (addr_i == OFS_STAT);
  assign wr_ien   = we_i && (addr_i == OFS_IEN);
  assign start_o  = wr_trig && !busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      trig_q  <= '0;
      epoch_q <= '0;
      stat_q  <= 1'b0;
      ien_q   <= 1'b0;
    end else begin
      if (wr_start) start_q <= wdata_i;
      if (wr_end)   end_q   <= wdata_i;
      if (wr_trig)  trig_q  <= wdata_i[23:0];
      if (wr_ien)   ien_q   <= wdata_i[0];
      if (start_o)     epoch_q <= '0;
      else if (done_i) epoch_q <= epoch_q + 1'b1;
      if (done_i)       stat_q <= 1'b1;
      else if (wr_stat) stat_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_START: rdata_o = start_q;
      OFS_END:   rdata_o = end_q;
      OFS_TRIG:  rdata_o = {TRIG_SIG, trig_q};
      OFS_CNT:   rdata_o = {{PAD_W{1'b0}}, epoch_q, busy_i};
      OFS_STAT:  rdata_o = {31'd0, stat_q & ien_q};
      OFS_IEN:   rdata_o = {31'd0, ien_q};
      default:   rdata_o = '0;
    endcase
  end

  assign win_start_o = start_q;
  assign win_end_o   = end_q;
  assign ien_o       = ien_q;
  assign irq_o       = stat_q & ien_q;
endmodule

// File: rtl/revsw_engine.sv
module revsw_engine
  import revsw_pkg::*;
#(
  parameter addr_t HEAP_BASE = 32'h0000_1000,
  parameter addr_t HEAP_SIZE = 32'h0000_0400,
  parameter addr_t BM_BASE   = 32'h0000_3000,
  parameter int    PERIOD    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              start_i,
  input  addr_t             win_start_i,
  input  addr_t             win_end_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              hm_req_o,
  output logic              hm_we_o,
  output addr_t             hm_addr_o,
  output logic [WORD_W-1:0] hm_wdata_o,
  output logic              hm_wtag_o,
  input  logic              hm_gnt_i,
  input  logic              hm_rvalid_i,
  input  logic [WORD_W-1:0] hm_rdata_i,
  input  logic              hm_rtag_i,
  output logic              bm_req_o,
  output addr_t             bm_addr_o,
  input  logic              bm_gnt_i,
  input  logic              bm_rvalid_i,
  input  logic [7:0]        bm_rdata_i
);
  localparam int CW  = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int IDW = ADDR_W - 3;

  eng_st_e           st_q;
  logic [IDW-1:0]    idx_q;
  logic [CW-1:0]     cnt_q;
  addr_t             addr_q;
  logic [WORD_W-1:0] data_q;

  addr_t cur_slot, ptr;
  logic  period_hit, slot_fire, past_end, below_start;

  assign cur_slot    = slot_addr(win_start_i, idx_q);
  assign past_end    = cur_slot >= win_end_i;
  assign below_start = cur_slot < win_start_i;
  assign period_hit  = cnt_q == CW'(PERIOD - 1);
  assign slot_fire   = (st_q == ST_WAIT) && tick_i && period_hit;
  assign done_o      = slot_fire && past_end;
  assign busy_o      = st_q != ST_IDLE;
  assign ptr         = data_q[31:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          idx_q <= '0;
          cnt_q <= '0;
          st_q  <= ST_WAIT;
        end
        ST_WAIT: if (tick_i) begin
          if (period_hit) begin
            cnt_q <= '0;
            idx_q <= idx_q + 1'b1;
            if (past_end) st_q <= ST_IDLE;
            else if (!below_start) begin
              addr_q <= cur_slot;
              st_q   <= ST_HRD;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HRD: if (hm_gnt_i) st_q <= ST_HRW;
        ST_HRW: if (hm_rvalid_i) begin
          data_q <= hm_rdata_i;
          st_q   <= (hm_rtag_i && in_heap(hm_rdata_i[31:0], HEAP_BASE, HEAP_SIZE))
                    ? ST_BRQ : ST_WAIT;
        end
        ST_BRQ: if (bm_gnt_i) st_q <= ST_BRW;
        ST_BRW: if (bm_rvalid_i)
          st_q <= bm_rdata_i[bm_bit(ptr, HEAP_BASE)] ? ST_HWR : ST_WAIT;
        ST_HWR: if (hm_gnt_i) st_q <= ST_HWW;
        ST_HWW: if (hm_rvalid_i) st_q <= ST_WAIT;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign hm_req_o   = (st_q == ST_HRD) || (st_q == ST_HWR);
  assign hm_we_o    = st_q == ST_HWR;
  assign hm_addr_o  = addr_q;
  assign hm_wdata_o = data_q;
  assign hm_wtag_o  = 1'b0;
  assign bm_req_o   = st_q == ST_BRQ;
  assign bm_addr_o  = bm_byte(ptr, HEAP_BASE, BM_BASE);
endmodule

// File: rtl/revoke_sweeper.sv
module revoke_sweeper
  import revsw_pkg::*;
#(
  parameter addr_t HEAP_BASE = 32'h0000_1000,
  parameter addr_t HEAP_SIZE = 32'h0000_0400,
  parameter addr_t BM_BASE   = 32'h0000_3000,
  parameter int    PERIOD    = 2,
  parameter int    EPOCH_W   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        reg_we_i,
  input  logic [15:0] reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        hm_req_o,
  output logic        hm_we_o,
  output logic [31:0] hm_addr_o,
  output logic [63:0] hm_wdata_o,
  output logic        hm_wtag_o,
  input  logic        hm_gnt_i,
  input  logic        hm_rvalid_i,
  input  logic [63:0] hm_rdata_i,
  input  logic        hm_rtag_i,
  output logic        bm_req_o,
  output logic [31:0] bm_addr_o,
  input  logic        bm_gnt_i,
  input  logic        bm_rvalid_i,
  input  logic [7:0]  bm_rdata_i,
  output logic        irq_o
);
  logic  sweep_busy, sweep_done, sweep_start, irq_en;
  addr_t win_start, win_end;

  revsw_regs #(.EPOCH_W(EPOCH_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .busy_i      (sweep_busy),
    .done_i      (sweep_done),
    .start_o     (sweep_start),
    .win_start_o (win_start),
    .win_end_o   (win_end),
    .ien_o       (irq_en),
    .irq_o       (irq_o)
  );

  revsw_engine #(
    .HEAP_BASE (HEAP_BASE),
    .HEAP_SIZE (HEAP_SIZE),
    .BM_BASE   (BM_BASE),
    .PERIOD    (PERIOD)
  ) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .start_i     (sweep_start),
    .win_start_i (win_start),
    .win_end_i   (win_end),
    .busy_o      (sweep_busy),
    .done_o      (sweep_done),
    .hm_req_o    (hm_req_o),
    .hm_we_o     (hm_we_o),
    .hm_addr_o   (hm_addr_o),
    .hm_wdata_o  (hm_wdata_o),
    .hm_wtag_o   (hm_wtag_o),
    .hm_gnt_i    (hm_gnt_i),
    .hm_rvalid_i (hm_rvalid_i),
    .hm_rdata_i  (hm_rdata_i),
    .hm_rtag_i   (hm_rtag_i),
    .bm_req_o    (bm_req_o),
    .bm_addr_o   (bm_addr_o),
    .bm_gnt_i    (bm_gnt_i),
    .bm_rvalid_i (bm_rvalid_i),
    .bm_rdata_i  (bm_rdata_i)
  );
endmodule

// File: rtl/revsw_checker.sv
module revsw_checker #(
  parameter logic [31:0] HEAP_SIZE = 32'h0000_0400,
  parameter logic [31:0] BM_BASE   = 32'h0000_3000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [15:0] reg_addr,
  input logic        hm_req,
  input logic        hm_we,
  input logic [31:0] hm_addr,
  input logic [63:0] hm_wdata,
  input logic        hm_gnt,
  input logic        bm_req,
  input logic [31:0] bm_addr,
  input logic        bm_gnt,
  input logic [31:0] win_start,
  input logic [31:0] win_end,
  input logic        busy,
  input logic        done,
  input logic        ien,
  input logic        irq
);
  localparam logic [31:0] BM_LAST = BM_BASE + ((HEAP_SIZE - 1) >> 6);

  // R11: heap request held steady until accepted
  a_r11_hm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hm_req && !hm_gnt |=> hm_req && $stable(hm_addr) && $stable(hm_we) && $stable(hm_wdata));

  // R11: bitmap request held steady until accepted
  a_r11_bm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bm_req && !bm_gnt |=> bm_req && $stable(bm_addr));

  // R11: never two ports at once
  a_r11_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(hm_req && bm_req));

  // R6: heap accesses aligned and inside the window
  a_r6_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    hm_req |-> (hm_addr[2:0] == 3'b000) && (hm_addr >= win_start) && (hm_addr < win_end));

  // R6: completion ends the sweep
  a_r6_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R8: bitmap byte stays inside the bitmap
  a_r8_bm_range: assert property (@(posedge clk) disable iff (!rst_n)
    bm_req |-> (bm_addr >= BM_BASE) && (bm_addr <= BM_LAST));

  // R3: trigger during a sweep does not stop it
  a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && (reg_addr == 16'h0008) && busy && !done |=> busy);

  // R10: completion with enable raises the interrupt
  a_r10_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    done && ien && !reg_we |=> irq);

  // R10: status write drops the interrupt
  a_r10_irq_clr: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && (reg_addr == 16'h0010) && !done |=> !irq);
endmodule

bind revoke_sweeper revsw_checker #(.HEAP_SIZE(HEAP_SIZE), .BM_BASE(BM_BASE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we_i),
  .reg_addr  (reg_addr_i),
  .hm_req    (hm_req_o),
  .hm_we     (hm_we_o),
  .hm_addr   (hm_addr_o),
  .hm_wdata  (hm_wdata_o),
  .hm_gnt    (hm_gnt_i),
  .bm_req    (bm_req_o),
  .bm_addr   (bm_addr_o),
  .bm_gnt    (bm_gnt_i),
  .win_start (win_start),
  .win_end   (win_end),
  .busy      (sweep_busy),
  .done      (sweep_done),
  .ien       (irq_en),
  .irq       (irq_o)
);

// File: tb/revoke_sweeper_tb.sv
`timescale 1ns/1ps
module revoke_sweeper_tb;
  localparam logic [31:0] HB = 32'h0000_1000;
  localparam logic [31:0] HS = 32'h0000_0400;
  localparam logic [31:0] BB = 32'h0000_3000;
  localparam int          PER = 2;
  localparam logic [31:0] REG0 = 32'h0000_8000;
  localparam int          NSLOT = 256;

  logic clk = 0, rst_n = 0, tick = 0;
  logic reg_we = 0;
  logic [15:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic hm_req, hm_we, hm_wtag, hm_gnt, hm_rvalid = 0, hm_rtag = 0;
  logic [31:0] hm_addr, bm_addr;
  logic [63:0] hm_wdata, hm_rdata = 0;
  logic bm_req, bm_gnt, bm_rvalid = 0, irq;
  logic [7:0] bm_rdata = 0;
  logic [1:0] stall = 0;

  int total = 0, bad = 0, finished = 0;
  int n_rd = 0, n_wr = 0, n_bm = 0, n_oob = 0;
  logic [63:0] mem_d [NSLOT];
  logic        mem_t [NSLOT];
  logic [7:0]  bmap [16];

  always #2 clk = ~clk;

  revoke_sweeper #(.HEAP_BASE(HB), .HEAP_SIZE(HS), .BM_BASE(BB), .PERIOD(PER)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .hm_req_o(hm_req), .hm_we_o(hm_we), .hm_addr_o(hm_addr), .hm_wdata_o(hm_wdata),
    .hm_wtag_o(hm_wtag), .hm_gnt_i(hm_gnt), .hm_rvalid_i(hm_rvalid), .hm_rdata_i(hm_rdata),
    .hm_rtag_i(hm_rtag), .bm_req_o(bm_req), .bm_addr_o(bm_addr), .bm_gnt_i(bm_gnt),
    .bm_rvalid_i(bm_rvalid), .bm_rdata_i(bm_rdata), .irq_o(irq)
  );

  always @(negedge clk) stall <= stall + 2'd1;
  assign hm_gnt = stall != 2'd0;
  assign bm_gnt = stall != 2'd1;

  always @(posedge clk) begin
    hm_rvalid <= 1'b0;
    bm_rvalid <= 1'b0;
    if (hm_req && hm_gnt) begin
      hm_rvalid <= 1'b1;
      if (hm_addr >= REG0 && hm_addr < REG0 + NSLOT * 8) begin
        if (hm_we) begin
          mem_d[(hm_addr - REG0) >> 3] = hm_wdata;
          mem_t[(hm_addr - REG0) >> 3] = hm_wtag;
          n_wr = n_wr + 1;
        end else begin
          hm_rdata <= mem_d[(hm_addr - REG0) >> 3];
          hm_rtag  <= mem_t[(hm_addr - REG0) >> 3];
          n_rd = n_rd + 1;
        end
      end else n_oob = n_oob + 1;
    end
    if (bm_req && bm_gnt) begin
      bm_rvalid <= 1'b1;
      if (bm_addr >= BB && bm_addr < BB + 16) bm_rdata <= bmap[bm_addr - BB];
      else n_oob = n_oob + 1;
      n_bm = n_bm + 1;
    end
  end

  function automatic logic [31:0] ptr_of(int i);
    return 32'h0FE0 + 32'(i) * 8 + 32'(i % 8);
  endfunction
  function automatic logic tag_of(int i);
    return (i % 7) != 3;
  endfunction
  function automatic logic [31:0] hi_of(int i);
    return 32'hC0FF_EE00 ^ (32'(i) * 32'h0101_0101);
  endfunction
  function automatic logic [7:0] bm_of(int k);
    return 8'((k * 59) ^ 150);
  endfunction
  function automatic logic heap_hit(int i);
    logic [31:0] p;
    p = ptr_of(i);
    return (p >= HB) && (p < HB + HS);
  endfunction
  function automatic logic revoked(int i);
    logic [31:0] off;
    off = ptr_of(i) - HB;
    if (!tag_of(i) || !heap_hit(i)) return 1'b0;
    return bm_of(int'(off >> 6))[off[5:3]];
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mem_init();
    for (int i = 0; i < NSLOT; i++) begin
      mem_d[i] = {hi_of(i), ptr_of(i)};
      mem_t[i] = tag_of(i);
    end
    for (int k = 0; k < 16; k++) bmap[k] = bm_of(k);
    n_rd = 0; n_wr = 0; n_bm = 0; n_oob = 0;
  endtask

  task automatic reg_wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic reg_rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    repeat (16) @(negedge clk);
  endtask

  task automatic run_idle(output int n);
    logic [31:0] d;
    n = 0;
    for (int k = 0; k < 2000; k++) begin
      pulse();
      n++;
      reg_rd(16'h000C, d);
      if (!d[0]) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n, ebm, ewr;
    mem_init();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state (R1 R2 R4 R10)
    reg_rd(16'h0000, d); chk("R1 reset start", d, 0);
    reg_rd(16'h0004, d); chk("R1 reset end", d, 0);
    reg_rd(16'h0008, d); chk("R2 reset trigger", d, 32'h5500_0000);
    reg_rd(16'h000C, d); chk("R4 reset counter", d, 0);
    reg_rd(16'h0014, d); chk("R10 reset enable", d, 0);
    chk("R10 reset irq", irq, 0);
    chk("R11 reset idle ports", {hm_req, bm_req}, 0);

    // R1 decode and unmapped
    reg_wr(16'h0000, 32'h1234_5678);
    reg_wr(16'h0004, 32'h9ABC_DEF0);
    reg_wr(16'h0018, 32'hFFFF_FFFF);
    reg_wr(16'h0002, 32'hFFFF_FFFF);
    reg_rd(16'h0000, d); chk("R1 start readback", d, 32'h1234_5678);
    reg_rd(16'h0004, d); chk("R1 end readback", d, 32'h9ABC_DEF0);
    reg_rd(16'h0018, d); chk("R1 unmapped read", d, 0);
    reg_rd(16'h0014, d); chk("R1 unmapped write ignored", d, 0);
    reg_wr(16'h000C, 32'hFFFF_FFFF);
    reg_rd(16'h000C, d); chk("R4 counter not writable", d, 0);

    // R5 pacing on an empty window
    reg_wr(16'h0000, REG0);
    reg_wr(16'h0004, REG0);
    reg_wr(16'h0008, 32'hAA12_3456);
    reg_rd(16'h0008, d); chk("R2 trigger readback", d, 32'h5512_3456);
    reg_rd(16'h000C, d); chk("R4 running flag", d, 1);
    pulse();
    reg_rd(16'h000C, d); chk("R5 first pulse no finish", d, 1);
    pulse();
    reg_rd(16'h000C, d); chk("R5 finish on pulse PERIOD", d, 2);
    chk("R6 empty window no access", n_rd + n_bm, 0);
    reg_rd(16'h0010, d); chk("R10 status gated off", d, 0);
    chk("R10 irq gated off", irq, 0);
    reg_wr(16'h0014, 32'hFFFF_FFFE);
    reg_rd(16'h0014, d); chk("R10 enable bit0 only", d, 0);
    reg_wr(16'h0014, 32'hFFFF_FFFF);
    reg_rd(16'h0014, d); chk("R10 enable set", d, 1);
    reg_rd(16'h0010, d); chk("R10 status visible", d, 1);
    chk("R10 irq raised", irq, 1);
    reg_wr(16'h0010, 32'h0);
    reg_rd(16'h0010, d); chk("R10 status cleared", d, 0);
    chk("R10 irq cleared", irq, 0);

    // full sweep over 136 slots (R6 R7 R8 R9 R5)
    mem_init();
    reg_wr(16'h0004, REG0 + 136 * 8);
    reg_wr(16'h0008, 32'h0);
    run_idle(n);
    chk("R5 full sweep pulses", n, 137 * PER);
    reg_rd(16'h000C, d); chk("R3 counter restarted then +1", d, 2);
    chk("R10 irq on completion", irq, 1);
    chk("R6 heap reads", n_rd, 136);
    ebm = 0; ewr = 0;
    for (int i = 0; i < 136; i++) begin
      if (tag_of(i) && heap_hit(i)) ebm++;
      if (revoked(i)) ewr++;
      chk($sformatf("R9 tag slot %0d", i), mem_t[i], tag_of(i) && !revoked(i));
      chk($sformatf("R9 word slot %0d", i), mem_d[i], {hi_of(i), ptr_of(i)});
    end
    chk("R7 R8 bitmap reads", n_bm, ebm);
    chk("R9 write-backs", n_wr, ewr);
    chk("R6 slot at end untouched", mem_t[136], tag_of(136));
    chk("R8 no stray access", n_oob, 0);
    reg_wr(16'h0010, 32'h5);

    // unaligned start (R6)
    mem_init();
    reg_wr(16'h0000, REG0 + 3);
    reg_wr(16'h0004, REG0 + 32'h20);
    reg_wr(16'h0008, 32'h0);
    run_idle(n);
    chk("R5 R6 unaligned pulses", n, 5 * PER);
    chk("R6 below-start slot skipped", n_rd, 3);

    // trigger during sweep (R3 R2)
    mem_init();
    reg_wr(16'h0000, REG0 + 32'h10000 - 32'h10000);
    reg_wr(16'h10 - 16'h10, REG0);
    reg_wr(16'h0004, REG0 + 8 * 8);
    reg_wr(16'h0008, 32'h0);
    for (int k = 0; k < 5; k++) pulse();
    reg_wr(16'h0008, 32'hABCD_EF12);
    reg_rd(16'h0008, d); chk("R2 value stored while running", d, 32'h55CD_EF12);
    reg_rd(16'h000C, d); chk("R3 still running", d, 1);
    run_idle(n);
    chk("R3 no restart pulses", n + 5, 9 * PER);
    chk("R3 no restart reads", n_rd, 8);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule